// File: doc/BRIEF.md
# General-Purpose I/O Port with Interrupt Detection

This block is a bank of up to 32 general-purpose pins behind a small word-wide register interface. Software picks a direction for every pin. It drives output values either by writing the whole output word or through separate write-one-to-set and write-one-to-clear locations. It reads pin levels back after they have been synchronized into the block's clock domain.

Every pin also carries an interrupt detector. Three configuration bits per pin choose the trigger: edge or level, which polarity, and an option to catch both edges. A trigger records a pending status bit when that pin's enable bit is on. Software clears the bit by writing a one to it. Status bits that are not masked are ORed into one registered interrupt request. Two pull-configuration words are kept as plain storage for the pad ring.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe`, `pin_out` and `irq` are 0, and reads of the set (0x10), clear (0x14) and status-clear (0x30) locations always return 0.
- R2: A write to 0x10 sets each output bit whose written bit is 1. A write to 0x14 clears each output bit whose written bit is 1. Output bits written as 0 keep their value.
- R3: A write to 0x00 loads the output word, which reads back at 0x00. `pin_out` equals that word. `pin_oe` equals the direction word at 0x08, where bit n = 1 drives pin n.
- R4: A read of 0x04 returns pin levels after a two-flop synchronizer. A change on `pin_in` shows up on the second rising clock edge after it.
- R5: With type bit 0 (edge), both-edge bit 0 and polarity bit 0, a rising pin edge sets status bit n at 0x24 three clock edges after the pin changes. A falling edge sets nothing.
- R6: With type 0, both-edge 0 and polarity 1, only falling edges set status.
- R7: With type 0 and both-edge 1, either edge sets status, whatever the polarity bit.
- R8: With type bit 1 (level), status is set on every clock while the pin sits at its active level: high for polarity 0, low for polarity 1.
- R9: Status bit n can become set only while enable bit n (0x20) is 1. Once set, it stays set until cleared.
- R10: Writing 1 to bit n of 0x30 clears status bit n. If a new event on pin n happens in the same cycle, the event wins and the bit stays set.
- R11: `irq` is a register holding the OR over all pins of status AND NOT mask (mask at 0x2C, bit 1 = masked). A masked pin still records status.
- R12: The pull-enable (0x18) and pull-type (0x1C) words are read/write storage and have no effect on pins, status or `irq`. Type is at 0x34, both-edge at 0x38 and polarity at 0x3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output values |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | Registered interrupt request |

## Verification
The detectors are driven with a rising pulse, a falling pulse, and a rise followed by a fall. Each pattern is applied under the rising, falling and both-edge settings, so every mode must fire on exactly the transitions it selects. A held level is used in level mode: clearing the status while the level stays active must not work, and clearing it after the level drops must work. The enable-off and mask-on cases separate recording status from raising the request. A mixed bit pattern on the set, clear and direct-write locations shows that zero bits leave the output alone.

// File: rtl/gpio_regmap_pkg.sv
package gpio_regmap_pkg;
   localparam int BUS_W = 32;
   localparam logic [7:0] OFS_DOUT   = 8'h00;
   localparam logic [7:0] OFS_DIN    = 8'h04;
   localparam logic [7:0] OFS_DIR    = 8'h08;
   localparam logic [7:0] OFS_SET    = 8'h10;
   localparam logic [7:0] OFS_CLR    = 8'h14;
   localparam logic [7:0] OFS_PULLEN = 8'h18;
   localparam logic [7:0] OFS_PULLTY = 8'h1C;
   localparam logic [7:0] OFS_IEN    = 8'h20;
   localparam logic [7:0] OFS_ISTAT  = 8'h24;
   localparam logic [7:0] OFS_IMASK  = 8'h2C;
   localparam logic [7:0] OFS_ICLR   = 8'h30;
   localparam logic [7:0] OFS_ITYPE  = 8'h34;
   localparam logic [7:0] OFS_IBOTH  = 8'h38;
   localparam logic [7:0] OFS_IPOL   = 8'h3C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 2) $error("gpio_sync: STAGES must be at least 2");
      if (W < 1)      $error("gpio_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic en,
   input  logic lvl_mode,
   input  logic both,
   input  logic pol,
   output logic evt
);
   logic prev;
   logic rise, fall, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   always_comb begin
      rise = lvl & ~prev;
      fall = ~lvl & prev;
      if (lvl_mode)  hit = pol ? ~lvl : lvl;
      else if (both) hit = rise | fall;
      else           hit = pol ? fall : rise;
      evt = en & hit;
   end

   // R5 R6: in edge mode an event needs a change since the last clock
   a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !lvl_mode) |-> (lvl != prev));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_regmap_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   localparam int PW = NPINS;

   initial begin
      if (NPINS < 1 || NPINS > BUS_W) $error("gpio_port: NPINS must be 1..32");
      if (ADDR_W < 8)                 $error("gpio_port: ADDR_W must be at least 8");
   end

   logic [PW-1:0] dout_q, dir_q, pull_en_q, pull_ty_q;
   logic [PW-1:0] ien_q, imask_q, itype_q, iboth_q, ipol_q, istat_q;
   logic [PW-1:0] pin_s, evt_vec, wd;
   logic [7:0]    wa;
   logic          irq_q;

   assign wd = wr_data[PW-1:0];
   assign wa = wr_addr[7:0];

   function automatic logic hit(input logic [7:0] a, input logic [7:0] ofs);
      return wr_en && (a == ofs) && (wr_addr >> 8) == '0;
   endfunction

   // pin synchronizer
   gpio_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   // per-pin detectors
   for (genvar n = 0; n < PW; n++) begin : g_pin
      gpio_evt_detect u_det (
         .clk(clk), .rst_n(rst_n), .lvl(pin_s[n]), .en(ien_q[n]),
         .lvl_mode(itype_q[n]), .both(iboth_q[n]), .pol(ipol_q[n]),
         .evt(evt_vec[n])
      );
   end

   // configuration and output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0; dir_q <= '0; pull_en_q <= '0; pull_ty_q <= '0;
         ien_q <= '0; imask_q <= '0; itype_q <= '0; iboth_q <= '0; ipol_q <= '0;
      end else begin
         if (hit(wa, OFS_DOUT))        dout_q <= wd;
         else if (hit(wa, OFS_SET))    dout_q <= dout_q | wd;
         else if (hit(wa, OFS_CLR))    dout_q <= dout_q & ~wd;
         if (hit(wa, OFS_DIR))    dir_q     <= wd;
         if (hit(wa, OFS_PULLEN)) pull_en_q <= wd;
         if (hit(wa, OFS_PULLTY)) pull_ty_q <= wd;
         if (hit(wa, OFS_IEN))    ien_q     <= wd;
         if (hit(wa, OFS_IMASK))  imask_q   <= wd;
         if (hit(wa, OFS_ITYPE))  itype_q   <= wd;
         if (hit(wa, OFS_IBOTH))  iboth_q   <= wd;
         if (hit(wa, OFS_IPOL))   ipol_q    <= wd;
      end
   end

   // pending status: write-one-to-clear, a same-cycle event wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 istat_q <= '0;
      else if (hit(wa, OFS_ICLR)) istat_q <= (istat_q & ~wd) | evt_vec;
      else                        istat_q <= istat_q | evt_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(istat_q & ~imask_q);
   end

   // combinational read port
   always_comb begin
      logic [PW-1:0] sel;
      sel     = '0;
      rd_data = '0;
      if ((rd_addr >> 8) == '0) begin
         case (rd_addr[7:0])
            OFS_DOUT:   sel = dout_q;
            OFS_DIN:    sel = pin_s;
            OFS_DIR:    sel = dir_q;
            OFS_PULLEN: sel = pull_en_q;
            OFS_PULLTY: sel = pull_ty_q;
            OFS_IEN:    sel = ien_q;
            OFS_ISTAT:  sel = istat_q;
            OFS_IMASK:  sel = imask_q;
            OFS_ITYPE:  sel = itype_q;
            OFS_IBOTH:  sel = iboth_q;
            OFS_IPOL:   sel = ipol_q;
            default:    sel = '0;
         endcase
      end
      rd_data[PW-1:0] = sel;
   end

   assign pin_out = dout_q;
   assign pin_oe  = dir_q;
   assign irq     = irq_q;

   // R2: set location forces written ones high
   a_r2_set_forces_ones: assert property (@(posedge clk) disable iff (!rst_n)
      hit(wa, OFS_SET) |=> ((dout_q & $past(wd)) == $past(wd)));
   // R2: clear location forces written ones low
   a_r2_clr_forces_zeros: assert property (@(posedge clk) disable iff (!rst_n)
      hit(wa, OFS_CLR) |=> ((dout_q & $past(wd)) == '0));
   // R9: no status bit rises without its enable
   a_r9_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((istat_q & ~$past(istat_q) & ~$past(ien_q)) == '0));
   // R10: an event is always recorded, even against a clear
   a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((istat_q & $past(evt_vec)) == $past(evt_vec)));
   // R10: a clear with no competing event takes effect
   a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (hit(wa, OFS_ICLR) && evt_vec == '0) |=> ((istat_q & $past(wd)) == '0));
   // R11: a request needs some pending status one cycle earlier
   a_r11_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(istat_q) != '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
   localparam logic [7:0] A_DOUT = 8'h00, A_DIN = 8'h04, A_DIR = 8'h08,
      A_SET = 8'h10, A_CLR = 8'h14, A_PEN = 8'h18, A_PTY = 8'h1C,
      A_IEN = 8'h20, A_ST = 8'h24, A_MSK = 8'h2C, A_ICL = 8'h30,
      A_TYP = 8'h34, A_BTH = 8'h38, A_POL = 8'h3C;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data, pin_in = '0, pin_out, pin_oe;
   logic irq;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_port u_gpio_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic quiesce();
      wr(A_IEN, '0); wr(A_TYP, '0); wr(A_BTH, '0); wr(A_POL, '0);
      wr(A_ICL, '1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_DOUT, v); chk("R1 dout", v, 0);
      rd(A_DIR, v);  chk("R1 dir", v, 0);
      rd(A_ST, v);   chk("R1 status", v, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 oe", pin_oe, 0);
   endtask

   task automatic t_output();
      logic [31:0] v;
      wr(A_DIR, 32'hFFFF_0000);
      chk("R3 oe", pin_oe, 32'hFFFF_0000);
      wr(A_DOUT, 32'h0000_00F0);
      rd(A_DOUT, v); chk("R3 dout readback", v, 32'h0000_00F0);
      wr(A_SET, 32'h0000_000F);
      rd(A_DOUT, v); chk("R2 set", v, 32'h0000_00FF);
      wr(A_CLR, 32'h0000_0030);
      rd(A_DOUT, v); chk("R2 clear", v, 32'h0000_00CF);
      chk("R3 pin_out", pin_out, 32'h0000_00CF);
      rd(A_SET, v); chk("R1 set reads 0", v, 0);
      rd(A_CLR, v); chk("R1 clr reads 0", v, 0);
      rd(A_ICL, v); chk("R1 iclr reads 0", v, 0);
   endtask

   task automatic t_datain();
      logic [31:0] v;
      @(negedge clk);
      pin_in = 32'hA5A5_1234;
      cyc(1); rd(A_DIN, v); chk("R4 one edge later old", v, 0);
      cyc(1); rd(A_DIN, v); chk("R4 two edges later new", v, 32'hA5A5_1234);
      pin_in = '0; cyc(3);
   endtask

   task automatic t_pull();
      logic [31:0] v;
      wr(A_PEN, 32'h0000_1234); wr(A_PTY, 32'h0000_FFFF);
      rd(A_PEN, v); chk("R12 pull enable", v, 32'h0000_1234);
      rd(A_PTY, v); chk("R12 pull type", v, 32'h0000_FFFF);
      chk("R12 pins unchanged", pin_out, 32'h0000_00CF);
      rd(A_ST, v); chk("R12 no status", v, 0);
   endtask

   task automatic t_rising();
      logic [31:0] v;
      wr(A_IEN, 32'h1);
      pin_in[0] = 1'b1; cyc(3);
      rd(A_ST, v); chk("R5 rising sets", v, 32'h1);
      wr(A_ICL, 32'h1);
      rd(A_ST, v); chk("R10 clear", v, 0);
      pin_in[0] = 1'b0; cyc(3);
      rd(A_ST, v); chk("R5 falling ignored", v, 0);
      quiesce();
   endtask

   task automatic t_falling();
      logic [31:0] v;
      wr(A_POL, 32'h2); wr(A_IEN, 32'h2);
      pin_in[1] = 1'b1; cyc(3);
      rd(A_ST, v); chk("R6 rising ignored", v, 0);
      pin_in[1] = 1'b0; cyc(3);
      rd(A_ST, v); chk("R6 falling sets", v, 32'h2);
      quiesce();
   endtask

   task automatic t_both();
      logic [31:0] v;
      wr(A_BTH, 32'h4); wr(A_POL, 32'h4); wr(A_IEN, 32'h4);
      pin_in[2] = 1'b1; cyc(3);
      rd(A_ST, v); chk("R7 rise sets", v, 32'h4);
      wr(A_ICL, 32'h4);
      pin_in[2] = 1'b0; cyc(3);
      rd(A_ST, v); chk("R7 fall sets", v, 32'h4);
      quiesce();
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(A_TYP, 32'h8); wr(A_IEN, 32'h8);
      pin_in[3] = 1'b1; cyc(3);
      rd(A_ST, v); chk("R8 high level sets", v, 32'h8);
      wr(A_ICL, 32'h8);
      rd(A_ST, v); chk("R10 event beats clear", v, 32'h8);
      pin_in[3] = 1'b0; cyc(3);
      wr(A_ICL, 32'h8);
      rd(A_ST, v); chk("R8 clear after level gone", v, 0);
      quiesce();
      wr(A_TYP, 32'h10); wr(A_POL, 32'h10); wr(A_IEN, 32'h10);
      cyc(1);
      rd(A_ST, v); chk("R8 low level sets", v, 32'h10);
      quiesce();
   endtask

   task automatic t_enable();
      logic [31:0] v;
      pin_in[5] = 1'b1; cyc(3);
      pin_in[5] = 1'b0; cyc(3);
      rd(A_ST, v); chk("R9 disabled no status", v, 0);
      pin_in[5] = 1'b1; cyc(3);
      wr(A_IEN, 32'h20); cyc(2);
      rd(A_ST, v); chk("R9 no stale event", v, 0);
      pin_in[5] = 1'b0; cyc(3);
      quiesce();
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(A_MSK, 32'h40); wr(A_IEN, 32'h40);
      pin_in[6] = 1'b1; cyc(4);
      rd(A_ST, v); chk("R11 masked still pending", v, 32'h40);
      chk("R11 masked no irq", {31'b0, irq}, 0);
      wr(A_MSK, 32'h0); cyc(1);
      chk("R11 unmasked irq", {31'b0, irq}, 1);
      wr(A_ICL, 32'h40); cyc(1);
      chk("R11 irq drops after clear", {31'b0, irq}, 0);
      pin_in[6] = 1'b0; cyc(3);
      quiesce();
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_output();
      t_datain();
      t_pull();
      t_rising();
      t_falling();
      t_both();
      t_level();
      t_enable();
      t_irq();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule